// File: doc/BRIEF.md
# Exception Entry Control Registers

This block keeps the three system-control registers that a 32-bit RISC core needs to take and leave exceptions: a mode/status word, a cause word and an exception return address. When the pipeline raises an exception request it gives a 5-bit cause code, the PC of the faulting instruction and a flag that says whether that instruction sat in a branch delay slot. On the next clock edge the block saves the return address, records the cause, and pushes the interrupt-enable/privilege pairs one level deeper. When the faulting instruction was in a delay slot, the saved address is moved back one word so that it points at the branch, and a flag is set in the cause word.

A return-from-exception strobe pops the mode stack. The core fetches the handler from a vector address that the block presents at all times. The boot-vector bit in the status word selects between two fixed handler bases. A small select/write-enable port lets software read and write the three registers. A write lands on the next edge.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset the status word is 0x00600000 (boot-vector bit 22 and TLB-off bit 21 set, all else zero), the cause word is 0 and the return address is 0.
- R2: An exception request for an instruction outside a delay slot loads the return address with the given PC on the next edge.
- R3: An exception request with the delay-slot flag set loads the return address with PC minus 4 and sets cause bit 31. Without the flag, cause bit 31 is cleared.
- R4: On entry, cause bits 7:0 are cleared and the 5-bit code is written into bits 6:2. Cause bits 30:8 keep their value.
- R5: On entry, status bits 5:2 take the previous bits 3:0 and bits 1:0 become 0, which means kernel mode with interrupts off. Status bits 31:6, including the interrupt masks in 15:8, are unchanged.
- R6: A return-from-exception strobe without an exception sets status bits 3:0 from the previous bits 5:2 and leaves every other status bit unchanged.
- R7: The vector output is 0xBFC00180 while status bit 22 is 1 and 0x80000080 while it is 0.
- R8: The register port uses select 0 for status, 1 for cause, 2 for the return address and 3 for no register. A write takes effect on the next edge. The read data shows the selected register combinationally. Select 3 reads 0, and a write to it changes nothing.
- R9: An exception request blocks every register-port write and any return strobe in the same cycle. A return strobe blocks a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | 5 | Cause code for the entry |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction was in a branch delay slot |
| rfe | input | 1 | Return-from-exception strobe |
| reg_we | input | 1 | Register port write enable |
| reg_sel | input | 2 | Register select (0 status, 1 cause, 2 return address, 3 none) |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data |
| status_o | output | 32 | Current status word |
| cause_o | output | 32 | Current cause word |
| epc_o | output | 32 | Current return address |
| vector_o | output | 32 | Exception handler address |

## Verification
Several updates can fall on the same edge. An exception entry can coincide with a software write to any of the three registers, or with a return strobe. A return strobe can coincide with a status write. The bench drives these pairs in one cycle, with write data chosen so that it is far from what the winning update produces. The scoreboard then compares all three registers, so a leaked write or a lost stack shift shows up as a wrong word. Delay-slot entries are run with cause bits 30:8 preloaded to ones, so that both the one-word return-address adjustment and the preserved upper cause bits are checked.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
    localparam int XLEN      = 32;
    localparam int CODE_W    = 5;
    localparam int CODE_LSB  = 2;
    localparam int BD_BIT    = 31;
    localparam int BEV_BIT   = 22;
    localparam int TS_BIT    = 21;
    localparam int STACK_W   = 6;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } cp0_sel_e;
endpackage

// File: rtl/cp0_status_reg.sv
module cp0_status_reg
    import cp0_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exc_take,
    input  logic         rfe_take,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] status_q
);
    localparam logic [W-1:0] RESET_VAL = (W'(1) << BEV_BIT) | (W'(1) << TS_BIT);

    typedef struct packed {
        logic [W-1:0] status;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (exc_take) begin
            nxt_d.status = {cur_q.status[W-1:STACK_W], cur_q.status[3:0], 2'b00};
        end else if (rfe_take) begin
            nxt_d.status = {cur_q.status[W-1:4], cur_q.status[5:2]};
        end else if (wr_en) begin
            nxt_d.status = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.status <= RESET_VAL;
        else        cur_q <= nxt_d;
    end

    assign status_q = cur_q.status;

    assert_entry_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
                  && (status_q[W-1:6] == $past(status_q[W-1:6])));

    assert_return_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_take && !exc_take) |=> (status_q[3:0] == $past(status_q[5:2]))
                                 && (status_q[W-1:4] == $past(status_q[W-1:4])));
endmodule

// File: rtl/cp0_cause_epc.sv
module cp0_cause_epc
    import cp0_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_take,
    input  logic [CW-1:0] exc_code,
    input  logic [W-1:0]  exc_pc,
    input  logic          exc_in_delay,
    input  logic          wr_cause,
    input  logic          wr_epc,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  cause_q,
    output logic [W-1:0]  epc_q
);
    localparam logic [W-1:0] CLR_MASK = (W'(1) << BD_BIT) | W'(8'hFF);

    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] epc;
    } ce_t;

    ce_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (exc_take) begin
            nxt_d.epc   = exc_in_delay ? (exc_pc - W'(4)) : exc_pc;
            nxt_d.cause = (cur_q.cause & ~CLR_MASK)
                        | (W'(exc_code) << CODE_LSB)
                        | (W'(exc_in_delay) << BD_BIT);
        end else begin
            if (wr_cause) nxt_d.cause = wr_data;
            if (wr_epc)   nxt_d.epc   = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cause_q = cur_q.cause;
    assign epc_q   = cur_q.epc;

    assert_epc_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !exc_in_delay) |=> epc_q == $past(exc_pc));

    assert_epc_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_in_delay) |=> (epc_q == $past(exc_pc) - W'(4)) && cause_q[BD_BIT]);

    assert_cause_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (cause_q[CODE_LSB+CW-1:CODE_LSB] == $past(exc_code))
                  && (cause_q[1:0] == 2'b00) && !cause_q[7]
                  && (cause_q[30:8] == $past(cause_q[30:8])));
endmodule

// File: rtl/cp0_vector_sel.sv
module cp0_vector_sel
    import cp0_pkg::*;
#(
    parameter int           W        = XLEN,
    parameter logic [W-1:0] BOOT_VEC = 32'hBFC0_0180,
    parameter logic [W-1:0] NORM_VEC = 32'h8000_0080
) (
    input  logic [W-1:0] status,
    output logic [W-1:0] vector
);
    always_comb begin
        vector = status[BEV_BIT] ? BOOT_VEC : NORM_VEC;
    end
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
    import cp0_pkg::*;
#(
    parameter int              W        = XLEN,
    parameter int              CW       = CODE_W,
    parameter logic [W-1:0]    BOOT_VEC = 32'hBFC0_0180,
    parameter logic [W-1:0]    NORM_VEC = 32'h8000_0080
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_req,
    input  logic [CW-1:0] exc_code,
    input  logic [W-1:0]  exc_pc,
    input  logic          exc_in_delay,
    input  logic          rfe,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic [W-1:0]  status_o,
    output logic [W-1:0]  cause_o,
    output logic [W-1:0]  epc_o,
    output logic [W-1:0]  vector_o
);
    cp0_sel_e sel;
    logic     rfe_take, wr_status, wr_cause, wr_epc;

    always_comb begin
        sel       = cp0_sel_e'(reg_sel);
        rfe_take  = rfe && !exc_req;
        wr_status = reg_we && !exc_req && (sel == SEL_STATUS);
        wr_cause  = reg_we && !exc_req && (sel == SEL_CAUSE);
        wr_epc    = reg_we && !exc_req && (sel == SEL_EPC);
    end

    cp0_status_reg #(.W(W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_take (exc_req),
        .rfe_take (rfe_take),
        .wr_en    (wr_status),
        .wr_data  (reg_wdata),
        .status_q (status_o)
    );

    cp0_cause_epc #(.W(W), .CW(CW)) u_cause_epc (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_take     (exc_req),
        .exc_code     (exc_code),
        .exc_pc       (exc_pc),
        .exc_in_delay (exc_in_delay),
        .wr_cause     (wr_cause),
        .wr_epc       (wr_epc),
        .wr_data      (reg_wdata),
        .cause_q      (cause_o),
        .epc_q        (epc_o)
    );

    cp0_vector_sel #(.W(W), .BOOT_VEC(BOOT_VEC), .NORM_VEC(NORM_VEC)) u_vec (
        .status (status_o),
        .vector (vector_o)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_o;
            SEL_CAUSE:  reg_rdata = cause_o;
            SEL_EPC:    reg_rdata = epc_o;
            default:    reg_rdata = '0;
        endcase
    end

    assert_vector_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[BEV_BIT] |-> vector_o == BOOT_VEC);

    assert_epc_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !exc_req && reg_sel == 2'd2) |=> epc_o == $past(reg_wdata));

    assert_exc_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && reg_we && reg_sel == 2'd1) |=> cause_o[6:2] == $past(exc_code));

    assert_none_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd3 && !exc_req && !rfe) |=>
            $stable(status_o) && $stable(cause_o) && $stable(epc_o));
endmodule

// File: tb/tb_cp0_exc_unit.sv
module tb_cp0_exc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req, exc_in_delay, rfe, reg_we;
    logic [4:0]  exc_code;
    logic [31:0] exc_pc, reg_wdata;
    logic [1:0]  reg_sel;
    logic [31:0] reg_rdata, status_o, cause_o, epc_o, vector_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [31:0] status;
        logic [31:0] cause;
        logic [31:0] epc;
        logic [31:0] vector;
    } exp_t;

    exp_t sb_q[$];
    logic [31:0] m_status, m_cause, m_epc;

    always #5 clk = ~clk;

    cp0_exc_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .rfe(rfe),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .status_o(status_o), .cause_o(cause_o),
        .epc_o(epc_o), .vector_o(vector_o)
    );

    function automatic logic [31:0] vec_of(logic [31:0] s);
        return s[22] ? 32'hBFC0_0180 : 32'h8000_0080;
    endfunction

    // monitor: compare queued expectations once the design has updated
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (status_o !== e.status || cause_o !== e.cause ||
                epc_o !== e.epc || vector_o !== e.vector) begin
                errors++;
                $display("FAIL %s: status/cause/epc/vector got %h %h %h %h expected %h %h %h %h",
                         e.req, status_o, cause_o, epc_o, vector_o,
                         e.status, e.cause, e.epc, e.vector);
            end
        end
    end

    task automatic idle_inputs();
        exc_req = 0; exc_code = '0; exc_pc = '0; exc_in_delay = 0;
        rfe = 0; reg_we = 0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    // driver: apply one cycle of stimulus, predict, push expectation
    task automatic step(string req, bit ex, logic [4:0] code, logic [31:0] pc,
                        bit dly, bit rt, bit we, logic [1:0] sel, logic [31:0] wd);
        exp_t e;
        exc_req = ex; exc_code = code; exc_pc = pc; exc_in_delay = dly;
        rfe = rt; reg_we = we; reg_sel = sel; reg_wdata = wd;
        if (ex) begin
            m_epc    = dly ? pc - 32'd4 : pc;
            m_cause  = (m_cause & 32'h7FFF_FF00) | ({27'd0, code} << 2) | ({31'd0, dly} << 31);
            m_status = {m_status[31:6], m_status[3:0], 2'b00};
        end else begin
            if (rt) m_status = {m_status[31:4], m_status[5:2]};
            if (we) begin
                case (sel)
                    2'd0: if (!rt) m_status = wd;
                    2'd1: m_cause = wd;
                    2'd2: m_epc = wd;
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        e.req = req; e.status = m_status; e.cause = m_cause;
        e.epc = m_epc; e.vector = vec_of(m_status);
        sb_q.push_back(e);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_read(string req, logic [1:0] sel, logic [31:0] exp);
        reg_sel = sel;
        #2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read sel %0d got %h expected %h", req, sel, reg_rdata, exp);
        end
        reg_sel = 2'd3;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        m_status = 32'h0060_0000; m_cause = '0; m_epc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset values
        checks++;
        if (status_o !== 32'h0060_0000 || cause_o !== 0 || epc_o !== 0 || vector_o !== 32'hBFC0_0180) begin
            errors++;
            $display("FAIL R1: got %h %h %h %h expected 00600000 0 0 bfc00180",
                     status_o, cause_o, epc_o, vector_o);
        end
        @(negedge clk);

        // R8 + R7: status write clears boot-vector bit
        step("R8_R7 status write", 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_FF2D);
        check_read("R8 read status", 2'd0, 32'h0000_FF2D);
        // R2 R4 R5 plain entry
        step("R2_R4_R5 plain entry", 1, 5'd8, 32'h0000_1000, 0, 0, 0, 2'd3, 0);
        check_read("R8 read epc", 2'd2, 32'h0000_1000);
        // R8 cause preload with upper bits set
        step("R8 cause write", 0, 0, 0, 0, 0, 1, 2'd1, 32'h7FFF_FFFF);
        check_read("R8 read cause", 2'd1, 32'h7FFF_FFFF);
        // R3 R4 delay-slot entry
        step("R3_R4 delay entry", 1, 5'd5, 32'h0000_2004, 1, 0, 0, 2'd3, 0);
        check_read("R3 read cause", 2'd1, 32'hFFFF_FF14);
        // R3 plain entry clears bit 31
        step("R3 plain clears bd", 1, 5'd31, 32'h0000_3000, 0, 0, 0, 2'd3, 0);
        // R6 two pops
        step("R6 return pop", 0, 0, 0, 0, 1, 0, 2'd3, 0);
        step("R6 return pop again", 0, 0, 0, 0, 1, 0, 2'd3, 0);
        // R9 exception vs writes
        step("R9 exc beats epc write", 1, 5'd2, 32'h0000_4000, 0, 0, 1, 2'd2, 32'hDEAD_BEEF);
        step("R9 exc beats status write", 1, 5'd3, 32'h0000_5008, 1, 0, 1, 2'd0, 32'hFFFF_FFFF);
        step("R9 exc beats cause write", 1, 5'd12, 32'h0000_6000, 0, 0, 1, 2'd1, 32'h0000_0000);
        step("R9 exc beats return", 1, 5'd4, 32'h0000_7000, 1, 1, 0, 2'd3, 0);
        step("R9 return beats status write", 0, 0, 0, 0, 1, 1, 2'd0, 32'h0040_0000);
        // R8 select 3 ignored
        step("R8 sel none write", 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        check_read("R8 read none", 2'd3, 32'h0);
        // R7 boot vector back on
        step("R7 boot vector set", 0, 0, 0, 0, 0, 1, 2'd0, 32'h0040_0003);
        step("R5 entry keeps masks", 1, 5'd0, 32'h0000_8000, 0, 0, 0, 2'd3, 0);
        step("R6 return restores", 0, 0, 0, 0, 1, 0, 2'd3, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule